// File: doc/BRIEF.md
# Block-Granular DMA Request Generator

This block produces the level request line that a DMA controller watches when it feeds a hash engine that has no input buffer. The engine takes exactly one 512-bit block and then goes busy while it compresses it. The DMA request must therefore cover a whole block at once and must stay low while the engine cannot take data. The block counts the write-accepted strobes. It drops the request when the block is complete. It raises the request again only after the engine has gone busy and then signalled ready for the next block.

The number of transfers in a block follows a 2-bit transfer-size setting, because a 64-byte block arrives as 64 byte writes, 32 halfword writes or 16 word writes. A start pulse arms the block and loads the count. Before the first start, the block makes no request. Data packing and the hash itself live elsewhere.

Top module: `blk_dreq_gen`

## Requirements
- R1: After reset the request output is low and stays low until the first start pulse, even with the core ready; write-accepted strobes seen before that start have no effect on the count.
- R2: Transfers per block follow the size setting: encoding 0 (8-bit) gives 64, encoding 1 (16-bit) gives 32, encoding 2 (32-bit) gives 16.
- R3: The reserved size encoding 3 is treated as 32-bit, so a block is 16 transfers.
- R4: A start pulse, in any phase and even part way through a block, reloads the count from the current size setting and enables the request; a start that coincides with a write-accepted strobe wins, and the strobe is not counted.
- R5: The request is low from the first cycle after the clock edge at which the final transfer of a block is accepted.
- R6: After a block completes, the request stays low until the core-ready input has been sampled low and then sampled high. The request rises in the cycle after the edge that samples ready high, and a fresh full count is loaded at that point.
- R7: The request is never high while core-ready is low. It follows core-ready low within the same cycle, without waiting for a clock edge.
- R8: The size setting is taken only when the count is loaded; changing it part way through a block does not change that block's transfer count.
- R9: Write-accepted strobes that arrive while a completed block waits for the core are not counted against the next block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that arms a new hash run |
| xfer_size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word, 3 treated as word |
| core_ready_i | input | 1 | High while the hash core can take message data |
| wr_accept_i | input | 1 | One-cycle strobe per data write accepted by the core |
| dreq_o | output | 1 | Level DMA request covering one block |

## Verification
The hardest case to reach is the hand-off between blocks. Core-ready must be seen to drop and then recover, and strobes that arrive in that window must be ignored. The bench completes a block under every size encoding and then holds core-ready high for a few cycles, to show that the request does not rise again. It then drops core-ready for the 57-cycle compression window, with a stray strobe inside it. After ready returns, a complete second block must need exactly the full arithmetic count of transfers. Separate passes cover a restart part way through a block that lands on a strobe, a size change part way through a block, and ready going low in the middle of a block.

// File: rtl/blk_dreq_pkg.sv
package blk_dreq_pkg;

    // Phase of the block-request sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // not armed since reset
        PH_FEED   = 2'd1,  // block in flight, request follows core ready
        PH_DRAIN  = 2'd2,  // block delivered, waiting for core to go busy
        PH_REFILL = 2'd3   // core busy, waiting for it to become ready
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

endpackage

// File: rtl/blk_dreq_size_dec.sv
module blk_dreq_size_dec #(
    parameter int BLOCK_BYTES = 64,
    parameter int WORD_BYTES  = 4,
    parameter int SIZE_W      = 2,
    parameter int CNT_W       = 7
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [CNT_W-1:0]  load_o
);
    localparam int MAX_SHIFT = $clog2(WORD_BYTES);
    localparam int N_CODES   = 1 << SIZE_W;

    logic [CNT_W-1:0] per_code [N_CODES];

    // Each encoding halves the block length once per step up in width,
    // saturating at the widest transfer the bus supports.
    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        localparam int SHIFT = (g > MAX_SHIFT) ? MAX_SHIFT : g;
        assign per_code[g] = CNT_W'(BLOCK_BYTES >> SHIFT);
    end

    assign load_o = per_code[size_i];

endmodule

// File: rtl/blk_dreq_xfer_cnt.sv
module blk_dreq_xfer_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_en_i) begin
            cnt_d = load_val_i;
        end else if (dec_en_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/blk_dreq_gen.sv
module blk_dreq_gen
    import blk_dreq_pkg::*;
#(
    parameter int BLOCK_BYTES = 64,
    parameter int WORD_BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] xfer_size_i,
    input  logic       core_ready_i,
    input  logic       wr_accept_i,
    output logic       dreq_o
);
    localparam int SIZE_W = 2;
    localparam int CNT_W  = $clog2(BLOCK_BYTES + 1);

    seq_state_t       seq_d, seq_q;
    logic             load_en;
    logic             dec_en;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q_w;
    logic             cnt_last;
    logic             feeding;

    blk_dreq_size_dec #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .WORD_BYTES  (WORD_BYTES),
        .SIZE_W      (SIZE_W),
        .CNT_W       (CNT_W)
    ) u_size_dec (
        .size_i (xfer_size_i),
        .load_o (load_val)
    );

    blk_dreq_xfer_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en_i  (load_en),
        .load_val_i (load_val),
        .dec_en_i   (dec_en),
        .cnt_o      (cnt_q_w),
        .last_o     (cnt_last)
    );

    always_comb begin
        seq_d   = seq_q;
        load_en = 1'b0;
        dec_en  = 1'b0;
        if (start_i) begin
            // Start overrides everything, including a coincident strobe.
            seq_d.phase = PH_FEED;
            load_en     = 1'b1;
        end else begin
            unique case (seq_q.phase)
                PH_IDLE: begin
                    seq_d.phase = PH_IDLE;
                end
                PH_FEED: begin
                    if (wr_accept_i) begin
                        dec_en = 1'b1;
                        if (cnt_last) begin
                            seq_d.phase = PH_DRAIN;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (!core_ready_i) begin
                        seq_d.phase = PH_REFILL;
                    end
                end
                PH_REFILL: begin
                    if (core_ready_i) begin
                        seq_d.phase = PH_FEED;
                        load_en     = 1'b1;
                    end
                end
                default: begin
                    seq_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign feeding = (seq_q.phase == PH_FEED);
    assign dreq_o  = feeding && core_ready_i;

endmodule

// File: rtl/blk_dreq_chk.sv
module blk_dreq_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             core_ready_i,
    input logic             wr_accept_i,
    input logic             dreq_o,
    input logic             feeding,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_last,
    input logic [CNT_W-1:0] load_val
);
    // R4: a start pulse leaves the count at the decoded block length.
    a_r4_start_reload: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt == $past(load_val)));

    // R5: accepting the final transfer withdraws the request next cycle.
    a_r5_drop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (feeding && wr_accept_i && cnt_last && !start_i) |=> !dreq_o);

    // R2: each accepted transfer mid-block removes exactly one from the count.
    a_r2_one_per_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (feeding && wr_accept_i && !cnt_last && !start_i)
        |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R8: without a strobe or start, a block in flight keeps its count.
    a_r8_hold_in_feed: assert property (@(posedge clk) disable iff (!rst_n)
        (feeding && !wr_accept_i && !start_i) |=> $stable(cnt));

    // R9: while waiting on a busy core, strobes leave the count alone.
    a_r9_ignore_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!feeding && !start_i && !core_ready_i) |=> $stable(cnt));

    // R6: a block in flight always has transfers left to request.
    a_r6_feed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        feeding |-> (cnt != '0));

endmodule

bind blk_dreq_gen blk_dreq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .core_ready_i (core_ready_i),
    .wr_accept_i  (wr_accept_i),
    .dreq_o       (dreq_o),
    .feeding      (feeding),
    .cnt          (cnt_q_w),
    .cnt_last     (cnt_last),
    .load_val     (load_val)
);

// File: tb/blk_dreq_gen_tb.sv
`timescale 1ns/1ps
module blk_dreq_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [1:0] xfer_size_i;
    logic       core_ready_i;
    logic       wr_accept_i;
    logic       dreq_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    blk_dreq_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .xfer_size_i  (xfer_size_i),
        .core_ready_i (core_ready_i),
        .wr_accept_i  (wr_accept_i),
        .dreq_o       (dreq_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Expected block length, from the size encoding alone.
    function automatic int blk_len(input int sz);
        int sh;
        sh = (sz > 2) ? 2 : sz;
        return 64 >> sh;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // n back-to-back accepted transfers; the request must be high before each.
    task automatic accept_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(dreq_o, 1'b1, tag, $sformatf("request before transfer %0d", i));
            wr_accept_i = 1'b1;
            @(negedge clk);
            wr_accept_i = 1'b0;
        end
    endtask

    task automatic pulse_start(input int sz);
        xfer_size_i = 2'(sz);
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int n;
        rst_n        = 1'b0;
        start_i      = 1'b0;
        xfer_size_i  = 2'd2;
        core_ready_i = 1'b1;
        wr_accept_i  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dreq_o, 1'b0, "R1", "request after reset");

        // R1: strobes before the first start are ignored.
        wr_accept_i = 1'b1;
        repeat (5) @(negedge clk);
        wr_accept_i = 1'b0;
        chk(dreq_o, 1'b0, "R1", "request before start");

        for (int sz = 0; sz < 4; sz++) begin
            n = blk_len(sz);
            pulse_start(sz);
            chk(dreq_o, 1'b1, "R4", $sformatf("request after start size=%0d", sz));
            accept_n(n, (sz == 3) ? "R3" : "R2");
            chk(dreq_o, 1'b0, "R5", $sformatf("request after last of %0d", n));
            // Ready still high: no busy period seen, so no new request.
            repeat (4) begin
                @(negedge clk);
                chk(dreq_o, 1'b0, "R6", "request while ready never dropped");
            end
            core_ready_i = 1'b0;
            for (int c = 0; c < 57; c++) begin
                wr_accept_i = (c == 10);
                @(negedge clk);
                chk(dreq_o, 1'b0, "R7", "request while core busy");
            end
            wr_accept_i  = 1'b0;
            core_ready_i = 1'b1;
            @(negedge clk);
            chk(dreq_o, 1'b1, "R6", "request after core ready again");
            accept_n(n, "R9");
            chk(dreq_o, 1'b0, "R9", $sformatf("second block length %0d", n));
        end

        // R4: restart mid-block, landing on a strobe.
        pulse_start(2);
        accept_n(5, "R4");
        start_i     = 1'b1;
        wr_accept_i = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
        wr_accept_i = 1'b0;
        accept_n(16, "R4");
        chk(dreq_o, 1'b0, "R4", "full block after restart");

        // R7: ready dropping mid-block masks the request at once.
        pulse_start(1);
        accept_n(3, "R7");
        core_ready_i = 1'b0;
        #1;
        chk(dreq_o, 1'b0, "R7", "same-cycle masking");
        repeat (3) begin
            @(negedge clk);
            chk(dreq_o, 1'b0, "R7", "masked while busy");
        end
        core_ready_i = 1'b1;
        #1;
        chk(dreq_o, 1'b1, "R7", "request back with ready");
        @(negedge clk);
        accept_n(29, "R7");
        chk(dreq_o, 1'b0, "R7", "rest of halfword block");

        // R8: size change mid-block does not alter the count.
        pulse_start(0);
        xfer_size_i = 2'd2;
        accept_n(16, "R8");
        chk(dreq_o, 1'b1, "R8", "still requesting after 16 byte transfers");
        accept_n(48, "R8");
        chk(dreq_o, 1'b0, "R8", "byte block ends at 64");

        finish_run();
    end
endmodule